// File: doc/BRIEF.md
# Posted-Write Watchdog Timer

The block is a watchdog timer with two clocks. A register bus on the interface clock programs it. A slow functional clock, nominally 32 kHz, runs the counter. A 32-bit counter counts up from a programmed load value, driven either by every functional clock or by a power-of-two prescaler. When the counter wraps past all ones while the watchdog runs, the block drives a reset output for a fixed number of functional clocks and then reloads the counter from the load value. Software prevents this by writing a trigger value that differs from the previous one, which reloads the counter at once.

Writes to the control, load, trigger and key registers are posted. The bus side latches the data and raises a per-register pending flag. A toggle handshake carries the write into the functional domain, and the flag clears once that domain has taken the write in. The status register can be read at any time. Software polls it before each posted write, because a write to a register whose flag is still set is dropped. The counter can only be started or stopped by writing two key words in order to the key register. The counter value is read back through a Gray-coded two-stage synchronizer.

Top module: `wdog_posted`

## Requirements
- R1: Reset leaves the watchdog running with the counter and load value at `LOAD_RST`, control at 0 (prescaler off), all pending flags clear and `wdt_rst` low. The first timeout comes 2^32 − `LOAD_RST` functional clocks after reset release.
- R2: Word address 5 is the status register. Its bit 0 flags control (address 0), bit 2 flags load (address 1), bit 3 flags trigger (address 3) and bit 4 flags key (address 4). A flag is set in the interface cycle after an accepted write and stays set until the functional domain takes the write in. All other status bits read 0.
- R3: A bus write to a posted register whose pending flag is set is dropped. The readback and the value used by the functional domain both keep the earlier write.
- R4: Writing 0x0000BBBB and then 0x00004444 to the key register starts the counter, with the prescaler phase cleared.
- R5: Writing 0x0000AAAA and then 0x00005555 to the key register stops the counter. A stopped counter holds its value and raises no reset, but a trigger reload still sets it to the load value.
- R6: A key sequence is ignored, and the key state returns to idle, if its second word is wrong or if a posted control, load or trigger write arrives between its two words. A second word written alone has no effect.
- R7: A trigger write (address 3) whose value differs from the last trigger value reloads the counter from the load register and clears the prescaler phase. Writing the same value again does not reload.
- R8: While running, the counter advances by 1 per tick. A tick from all ones raises `wdt_rst` for exactly `RST_CYC` functional clocks; the counter then reloads. Successive reset pulses are therefore 4·2^p + `RST_CYC` clocks apart for a distance of 4 ticks to wrap.
- R9: Control bit 5 enables the prescaler and bits 4:2 hold p. When enabled, one tick occurs every 2^p functional clocks. When disabled, every functional clock is a tick, whatever p holds.
- R10: A read of address 2 returns the functional counter value after a Gray-coded two-stage synchronizer. For a stopped counter it equals the counter exactly.
- R11: Address 6 holds an interface-clock autogating enable in bit 0. It is written directly, not posted, reads back as written, and sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Interface (bus) clock |
| fclk | input | 1 | Functional counter clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Bus write strobe, one interface cycle per write |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for `addr`, combinational |
| wdt_rst | output | 1 | Watchdog reset pulse, functional domain |

## Verification
The assertions assume that a write happens only as a single-cycle `wr_en` strobe with a stable `addr`. They also assume that posted data stays unchanged while its pending flag is set, which the block itself guarantees by dropping writes. The bench issues every sequenced write through a task that polls the status register until the target flag clears, both before and after the write, so key words and configuration changes reach the functional domain strictly in order. Only the R2 and R3 checks write deliberately while a flag is still set. The bench reads the counter exactly only while the watchdog is stopped, so that a synchronized multi-bit value can be compared with no uncertainty.

// File: rtl/wdog_posted.sv
`timescale 1ns/1ps
module wdog_posted #(
  parameter logic [31:0] LOAD_RST = 32'hFFFF_F000,
  parameter int          RST_CYC  = 4
) (
  input  logic        bclk,
  input  logic        fclk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wdt_rst
);
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_CNT = 3'd2, A_TRIG = 3'd3,
                         A_KEY  = 3'd4, A_STAT = 3'd5, A_SCFG = 3'd6;
  localparam logic [31:0] KEY_ON1 = 32'h0000_BBBB, KEY_ON2 = 32'h0000_4444,
                          KEY_OFF1 = 32'h0000_AAAA, KEY_OFF2 = 32'h0000_5555;
  localparam int RC_W = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {K_IDLE, K_ON, K_OFF} kst_t;

  // interface domain
  logic [31:0] h_ctrl, h_load, h_trig, h_key;
  logic [3:0]  req, ack_s1, ack_s2, pend, hit, take;
  logic [31:0] cg_s1, cg_s2, cnt_rd;
  logic        autogate;

  // functional domain
  logic [3:0]  rq_s1, rq_s2, ack, evt;
  logic        pre_en, run;
  logic [2:0]  ptv;
  logic [31:0] load_f, trig_f, cnt, cnt_g;
  logic [6:0]  pcnt, mask;
  logic [RC_W-1:0] rst_cnt;
  kst_t        kst;
  logic        tick, reload_trig, other_evt;

  assign hit  = wr_en ? {addr == A_KEY, addr == A_TRIG, addr == A_LOAD, addr == A_CTRL} : 4'b0;
  assign pend = req ^ ack_s2;
  assign take = hit & ~pend;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      h_ctrl <= '0; h_load <= LOAD_RST; h_trig <= '0; h_key <= '0;
      req <= '0; ack_s1 <= '0; ack_s2 <= '0;
      cg_s1 <= LOAD_RST ^ (LOAD_RST >> 1); cg_s2 <= LOAD_RST ^ (LOAD_RST >> 1);
      autogate <= 1'b0;
    end else begin
      req    <= req ^ take;
      ack_s1 <= ack;
      ack_s2 <= ack_s1;
      cg_s1  <= cnt_g;
      cg_s2  <= cg_s1;
      if (take[0]) h_ctrl <= wdata;
      if (take[1]) h_load <= wdata;
      if (take[2]) h_trig <= wdata;
      if (take[3]) h_key  <= wdata;
      if (wr_en && addr == A_SCFG) autogate <= wdata[0];
    end
  end

  always_comb
    for (int i = 0; i < 32; i++) cnt_rd[i] = ^(cg_s2 >> i);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = h_ctrl;
      A_LOAD:  rdata = h_load;
      A_CNT:   rdata = cnt_rd;
      A_TRIG:  rdata = h_trig;
      A_KEY:   rdata = h_key;
      A_STAT:  rdata = {27'b0, pend[3], pend[2], pend[1], 1'b0, pend[0]};
      A_SCFG:  rdata = {31'b0, autogate};
      default: rdata = '0;
    endcase
  end

  assign evt         = rq_s2 ^ ack;
  assign mask        = 7'h7F >> (3'd7 - ptv);
  assign tick        = !pre_en || ((pcnt & mask) == mask);
  assign reload_trig = evt[2] && (h_trig != trig_f);
  assign other_evt   = |evt[2:0];
  assign wdt_rst     = rst_cnt != '0;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s1 <= '0; rq_s2 <= '0; ack <= '0;
      pre_en <= 1'b0; ptv <= '0; run <= 1'b1;
      load_f <= LOAD_RST; trig_f <= '0; cnt <= LOAD_RST;
      cnt_g <= LOAD_RST ^ (LOAD_RST >> 1);
      pcnt <= '0; rst_cnt <= '0; kst <= K_IDLE;
    end else begin
      rq_s1 <= req;
      rq_s2 <= rq_s1;
      ack   <= rq_s2;
      cnt_g <= cnt ^ (cnt >> 1);
      pcnt  <= pcnt + 7'd1;

      if (evt[0]) begin
        pre_en <= h_ctrl[5];
        ptv    <= h_ctrl[4:2];
      end
      if (evt[1]) load_f <= h_load;
      if (evt[2]) trig_f <= h_trig;

      if (rst_cnt != '0) begin
        rst_cnt <= rst_cnt - 1'b1;
        if (rst_cnt == RC_W'(1)) begin
          cnt  <= load_f;
          pcnt <= '0;
        end
      end else if (run && tick) begin
        cnt <= cnt + 32'd1;
        if (cnt == '1) rst_cnt <= RC_W'(RST_CYC);
      end

      if (reload_trig) begin
        cnt  <= load_f;
        pcnt <= '0;
      end

      if (other_evt) kst <= K_IDLE;
      else if (evt[3]) begin
        case (kst)
          K_IDLE: kst <= (h_key == KEY_ON1) ? K_ON : (h_key == KEY_OFF1) ? K_OFF : K_IDLE;
          K_ON: begin
            if (h_key == KEY_ON2) begin
              run  <= 1'b1;
              pcnt <= '0;
            end
            kst <= K_IDLE;
          end
          K_OFF: begin
            if (h_key == KEY_OFF2) run <= 1'b0;
            kst <= K_IDLE;
          end
          default: kst <= K_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdog_posted_chk.sv
`timescale 1ns/1ps
module wdog_posted_chk #(
  parameter int RST_CYC = 4
) (
  input logic        bclk,
  input logic        fclk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [3:0]  pend,
  input logic [31:0] h_load,
  input logic        run,
  input logic [31:0] cnt,
  input logic [3:0]  evt,
  input logic        wdt_rst
);
  int hi;

  always_ff @(posedge fclk or negedge rst_n)
    if (!rst_n) hi <= 0;
    else        hi <= wdt_rst ? hi + 1 : 0;

  // address 1 is the load register, pend[1] its flag
  AST_PEND_RAISE: assert property (@(posedge bclk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !pend[1]) |=> pend[1]); // R2
  AST_DROP_PENDING: assert property (@(posedge bclk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && pend[1]) |=> $stable(h_load)); // R3
  AST_STOPPED_HOLDS: assert property (@(posedge fclk) disable iff (!rst_n)
    (!run && !wdt_rst && !evt[2]) |=> $stable(cnt)); // R5
  AST_RST_NOT_LONG: assert property (@(posedge fclk) disable iff (!rst_n)
    wdt_rst |-> hi < RST_CYC); // R8
  AST_RST_FULL_LEN: assert property (@(posedge fclk) disable iff (!rst_n)
    $fell(wdt_rst) |-> hi == RST_CYC); // R8
endmodule

bind wdog_posted wdog_posted_chk #(.RST_CYC(RST_CYC)) u_chk (
  .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .pend(pend), .h_load(h_load), .run(run), .cnt(cnt), .evt(evt), .wdt_rst(wdt_rst)
);

// File: tb/tb_wdog_posted.sv
`timescale 1ns/1ps
module tb_wdog_posted;
  localparam logic [31:0] LRST = 32'hFFFF_FF00;
  localparam int RC = 4;
  localparam logic [2:0] A_CTRL = 0, A_LOAD = 1, A_CNT = 2, A_TRIG = 3, A_KEY = 4, A_STAT = 5, A_SCFG = 6;

  logic bclk = 0, fclk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic wdt_rst;

  int tests = 0, fails = 0;
  int fe = 0, fe_rel = 0, rise_cnt = 0, rise_last = 0, rise_prev = 0, fall_last = 0;
  logic prev_rst = 0;

  wdog_posted #(.LOAD_RST(LRST), .RST_CYC(RC)) dut (
    .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

  always #10 bclk = ~bclk;
  always #35 fclk = ~fclk;

  always @(posedge fclk) fe <= fe + 1;
  always @(negedge fclk) begin
    if (wdt_rst && !prev_rst) begin
      rise_prev <= rise_last; rise_last <= fe; rise_cnt <= rise_cnt + 1;
    end
    if (!wdt_rst && prev_rst) fall_last <= fe;
    prev_rst <= wdt_rst;
  end

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge bclk); wr_en = 1; addr = a; wdata = d;
    @(negedge bclk); wr_en = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] v);
    @(negedge bclk); addr = a; #2; v = rdata;
  endtask

  task automatic wait_clear(int b);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_rd(A_STAT, v);
      if (!v[b]) return;
    end
    check("R2 pending never clears", 1, 0);
  endtask

  function automatic int pbit(logic [2:0] a);
    case (a)
      A_CTRL: return 0; A_LOAD: return 2; A_TRIG: return 3; default: return 4;
    endcase
  endfunction

  task automatic post(logic [2:0] a, logic [31:0] d);
    wait_clear(pbit(a)); bus_wr(a, d); wait_clear(pbit(a));
  endtask

  task automatic wait_rises(int k);
    int tgt = rise_cnt + k;
    for (int i = 0; i < 6000 && rise_cnt < tgt; i++) @(negedge fclk);
    if (rise_cnt < tgt) check("R8 reset pulse missing", 0, 1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge bclk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    int rc0;
    #203; rst_n = 1; fe_rel = fe;
    // R1 reset state
    bus_rd(A_STAT, v); check("R1 status", v, 0);
    bus_rd(A_CTRL, v); check("R1 control", v, 0);
    bus_rd(A_LOAD, v); check("R1 load", v, LRST);
    check("R1 reset output low", wdt_rst, 0);
    wait_rises(1);
    check("R1 first timeout edge", rise_last - fe_rel, 32'd256);
    wait_rises(1);
    check("R8 pulse width", fall_last - rise_prev, RC);
    check("R8 period no prescale", rise_last - rise_prev, 256 + RC);

    // R9 prescaler sweep with 4 ticks to wrap
    post(A_LOAD, 32'hFFFF_FFFC);
    post(A_CTRL, 32'h0000_001C);
    wait_rises(2);
    check("R9 disabled ignores p", rise_last - rise_prev, 4 + RC);
    for (int p = 0; p < 8; p++) begin
      post(A_CTRL, 32'h20 | (p << 2));
      wait_rises(2);
      check($sformatf("R9 R8 period p=%0d", p), rise_last - rise_prev, (4 << p) + RC);
    end
    post(A_CTRL, 0);
    wait_rises(2);
    check("R9 disabled again", rise_last - rise_prev, 4 + RC);

    // R5 stop, R7 trigger reloads, R10 counter read
    post(A_KEY, 32'hAAAA); post(A_KEY, 32'h5555);
    idle(60); rc0 = rise_cnt;
    post(A_LOAD, 32'h1234_5678); post(A_TRIG, 32'h1); idle(20);
    bus_rd(A_CNT, v); check("R7 R10 reload on new trigger", v, 32'h1234_5678);
    post(A_LOAD, 32'h0000_ABCD); post(A_TRIG, 32'h1); idle(20);
    bus_rd(A_CNT, v); check("R7 same trigger no reload", v, 32'h1234_5678);
    post(A_TRIG, 32'h2); idle(20);
    bus_rd(A_CNT, v); check("R7 second reload", v, 32'h0000_ABCD);
    idle(300);
    bus_rd(A_CNT, v); check("R5 stopped holds", v, 32'h0000_ABCD);
    check("R5 no pulse when stopped", rise_cnt, rc0);

    // R6 bad start sequences
    post(A_KEY, 32'hBBBB); post(A_KEY, 32'h4445); idle(100);
    bus_rd(A_CNT, v); check("R6 wrong start word", v, 32'h0000_ABCD);
    post(A_KEY, 32'hBBBB); post(A_CTRL, 0); post(A_KEY, 32'h4444); idle(100);
    bus_rd(A_CNT, v); check("R6 write between start words", v, 32'h0000_ABCD);
    post(A_KEY, 32'h4444); idle(100);
    bus_rd(A_CNT, v); check("R6 lone second word", v, 32'h0000_ABCD);

    // R4 start
    post(A_KEY, 32'hBBBB); post(A_KEY, 32'h4444); idle(100);
    bus_rd(A_CNT, v);
    check("R4 counting after start", (v > 32'hABCD) && (v < 32'hABCD + 1000), 1);

    // R6 bad stop sequences
    post(A_KEY, 32'hAAAA); post(A_KEY, 32'h1234);
    bus_rd(A_CNT, c1); idle(60); bus_rd(A_CNT, c2);
    check("R6 wrong stop word", c2 > c1, 1);
    post(A_KEY, 32'h5555);
    bus_rd(A_CNT, c1); idle(60); bus_rd(A_CNT, c2);
    check("R6 lone stop word", c2 > c1, 1);
    post(A_KEY, 32'hAAAA); post(A_TRIG, 32'h3); post(A_KEY, 32'h5555);
    bus_rd(A_CNT, c1); idle(60); bus_rd(A_CNT, c2);
    check("R6 write between stop words", c2 > c1, 1);
    check("R7 running reload near load", c1 < 32'hABCD + 1000, 1);

    // R5 proper stop
    post(A_KEY, 32'hAAAA); post(A_KEY, 32'h5555); idle(20);
    bus_rd(A_CNT, c1); idle(100); bus_rd(A_CNT, c2);
    check("R5 stop freezes counter", c2, c1);

    // R2 pending flags
    bus_wr(A_LOAD, 32'h0000_1111); bus_rd(A_STAT, v); check("R2 load flag bit2", v, 32'h4);
    wait_clear(2); bus_rd(A_STAT, v); check("R2 load flag clears", v, 0);
    bus_wr(A_CTRL, 0); bus_rd(A_STAT, v); check("R2 control flag bit0", v, 32'h1);
    wait_clear(0);
    bus_wr(A_TRIG, 32'h3); bus_rd(A_STAT, v); check("R2 trigger flag bit3", v, 32'h8);
    wait_clear(3);
    bus_wr(A_KEY, 0); bus_rd(A_STAT, v); check("R2 key flag bit4", v, 32'h10);
    wait_clear(4);

    // R3 drop while pending
    bus_wr(A_LOAD, 32'h0000_2222); bus_wr(A_LOAD, 32'h0000_3333);
    wait_clear(2);
    bus_rd(A_LOAD, v); check("R3 readback keeps first", v, 32'h0000_2222);
    post(A_TRIG, 32'h4); idle(20);
    bus_rd(A_CNT, v); check("R3 functional keeps first", v, 32'h0000_2222);

    // R11 autogate bit
    bus_wr(A_SCFG, 32'h1); bus_rd(A_STAT, v); check("R11 not posted", v, 0);
    bus_rd(A_SCFG, v); check("R11 readback one", v, 1);
    bus_wr(A_SCFG, 32'h0); bus_rd(A_SCFG, v); check("R11 readback zero", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule